// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the registered array address of a synchronous burst SRAM. When an address strobe is sampled low and the cycle controller has qualified the start, the full external address is captured. The block then produces the remaining addresses of a four-beat burst by itself, stepping only the two least significant bits. The upper bits never change during a burst.

A static mode input sets the order of the low bits. In linear order they count up modulo four from the loaded value. In interleaved order they are the loaded low bits XORed with the beat number. The address is presented straight from the registers with no further pipeline stage, so the array can be read in the same cycle.

The sequencer is a five-state machine. ST_IDLE means no address has been loaded since reset. ST_BEAT0 to ST_BEAT3 give the beat number. The transitions are:
- LOAD: from any state to ST_BEAT0 on a qualified strobe.
- STEP: ST_BEATn to ST_BEAT(n+1). From ST_BEAT3, STEP wraps to ST_BEAT0.
- HOLD: the state stays as it is.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, `arr_addr` is 0 and the sequencer is idle.
- R2: If `start_ok` is 1 and either `strb_proc_n` or `strb_ctrl_n` is 0 at a rising edge, `arr_addr` equals the sampled `ext_addr` after that edge.
- R3: A strobe sampled low while `start_ok` is 0 does not load and does not advance, so `arr_addr` keeps its value.
- R4: `adv_n` has no effect on an edge that loads. The loaded address is output unchanged, with beat 0.
- R5: The address advances one beat only when all of the following hold: both strobes are 1, `adv_n` is 0, `beat_qual` is 1, and a burst is active.
- R6: With `order_sel` = 0 (linear), the low two bits equal (loaded low bits + beat) mod 4, and bits 18:2 stay at the loaded value.
- R7: With `order_sel` = 1 (interleaved), the low two bits equal the loaded low bits XOR beat, and bits 18:2 stay at the loaded value.
- R8: A step taken from the fourth beat (beat 3) returns the address to the loaded start address (beat 0).
- R9: A qualified strobe in the middle of a burst reloads the address and restarts at beat 0.
- R10: When `beat_qual` is 0, a low `adv_n` with both strobes high leaves `arr_addr` unchanged. The cycle controller drives `beat_qual` from the byte write strobes during write bursts.
- R11: Before the first load after reset, advance requests leave `arr_addr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | 19 | External address to load |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| start_ok | input | 1 | Start qualified by the cycle controller (chip enables valid) |
| adv_n | input | 1 | Burst advance request, active low |
| beat_qual | input | 1 | Advance qualifier: 1 in read bursts; in write bursts, 1 only when a byte write strobe is active |
| order_sel | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| arr_addr | output | 19 | Current array address |

## Verification
A wrong beat state appears on `arr_addr` on the cycle right after the edge that produced it, because the address is formed from the registers alone. A beat that skips or sticks gives a wrong low-bit pair on the next advance. A corrupted base register shows up as wrong upper bits on every later beat of the burst. A stale beat count after a mid-burst reload shows as a nonzero offset on the first beat. Any of these faults is therefore visible within one cycle of its cause.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W   = 2;
    localparam int BURST_LEN = 1 << BEAT_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } seq_state_t;

    function automatic logic [BEAT_W-1:0] beat_of(input seq_state_t s);
        case (s)
            ST_BEAT1: return 2'd1;
            ST_BEAT2: return 2'd2;
            ST_BEAT3: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            base_addr <= '0;
        else if (load)
            base_addr <= ext_addr;
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output seq_state_t        state,
    output logic [BEAT_W-1:0] beat,
    output logic              busy
);

    seq_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions: LOAD, STEP, HOLD
    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = ST_BEAT0;
        end else if (step) begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_BEAT0: state_nx = ST_BEAT1;
                ST_BEAT1: state_nx = ST_BEAT2;
                ST_BEAT2: state_nx = ST_BEAT3;
                ST_BEAT3: state_nx = ST_BEAT0;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        beat = beat_of(state);
        busy = (state != ST_IDLE);
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] xor_lo;

    always_comb begin
        lin_lo  = start_lo + beat;
        xor_lo  = start_lo ^ beat;
        addr_lo = order_sel ? xor_lo : lin_lo;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              start_ok,
    input  logic              adv_n,
    input  logic              beat_qual,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] arr_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] base_addr;
    seq_state_t        state;
    logic [BEAT_W-1:0] beat;
    logic              busy;
    logic [BEAT_W-1:0] addr_lo;

    always_comb begin
        load = start_ok & (~strb_proc_n | ~strb_ctrl_n);
        step = strb_proc_n & strb_ctrl_n & ~adv_n & beat_qual;
    end

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ext_addr  (ext_addr),
        .base_addr (base_addr)
    );

    burst_beat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .state (state),
        .beat  (beat),
        .busy  (busy)
    );

    burst_order_map u_map (
        .start_lo  (base_addr[BEAT_W-1:0]),
        .beat      (beat),
        .order_sel (order_sel),
        .addr_lo   (addr_lo)
    );

    always_comb begin
        arr_addr = {base_addr[ADDR_W-1 -: HI_W], addr_lo};
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strb_proc_n,
    input logic              strb_ctrl_n,
    input logic              start_ok,
    input logic              adv_n,
    input logic              beat_qual,
    input logic              order_sel,
    input logic              busy,
    input logic [ADDR_W-1:0] arr_addr
);

    logic ld_c, st_c;
    always_comb begin
        ld_c = start_ok && (!strb_proc_n || !strb_ctrl_n);
        st_c = strb_proc_n && strb_ctrl_n && !adv_n && beat_qual;
    end

    // R2, R4, R9: loaded address appears as is
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_c |=> arr_addr == $past(ext_addr));

    // R3, R10: no load and no step keeps the address
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_c && !st_c) |=> (order_sel != $past(order_sel)) || (arr_addr == $past(arr_addr)));

    // R6, R7: upper bits fixed across a step
    a_r6_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_c && st_c && busy) |=> arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2]));

    // R6, R8: linear step adds one modulo four
    a_r6_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_c && st_c && busy && !order_sel) |=>
            (order_sel || arr_addr[1:0] == $past(arr_addr[1:0]) + 2'd1));

    // R7: interleaved step always flips bit 0
    a_r7_inter: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_c && st_c && busy && order_sel) |=>
            (!order_sel || (arr_addr[0] != $past(arr_addr[0]))));

    // R11: idle ignores advance
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_c && !busy) |=> arr_addr == $past(arr_addr));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr    (ext_addr),
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .start_ok    (start_ok),
    .adv_n       (adv_n),
    .beat_qual   (beat_qual),
    .order_sel   (order_sel),
    .busy        (busy),
    .arr_addr    (arr_addr)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          strb_proc_n, strb_ctrl_n, start_ok, adv_n, beat_qual, order_sel;
    logic [AW-1:0] arr_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    bit            m_busy;
    string         m_tag;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .start_ok(start_ok), .adv_n(adv_n), .beat_qual(beat_qual),
        .order_sel(order_sel), .arr_addr(arr_addr)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] bt, logic ord);
        logic [1:0] lo;
        lo = ord ? (b[1:0] ^ bt) : (b[1:0] + bt);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(string tag);
        logic [AW-1:0] e;
        e = exp_addr(m_base, m_beat, order_sel);
        n_chk++;
        if (arr_addr !== e) begin
            n_bad++;
            $display("FAIL %s: arr_addr=%h expected=%h", tag, arr_addr, e);
        end
    endtask

    // apply inputs at negedge, update model, check at the next negedge
    task automatic cyc(logic [AW-1:0] a, logic p_n, logic c_n, logic ok,
                       logic av_n, logic q, logic ord);
        bit ld, st;
        ext_addr = a; strb_proc_n = p_n; strb_ctrl_n = c_n; start_ok = ok;
        adv_n = av_n; beat_qual = q; order_sel = ord;
        ld = ok && (!p_n || !c_n);
        st = p_n && c_n && !av_n && q;
        if (ld) begin
            m_tag = m_busy ? "R9" : ((!p_n && !av_n) ? "R4" : "R2");
            m_base = a; m_beat = 2'd0; m_busy = 1;
        end else if (!m_busy) begin
            m_tag = "R11";
        end else if (st) begin
            m_tag = (m_beat == 2'd3) ? "R8" : (ord ? "R7" : "R6");
            m_beat = m_beat + 2'd1;
        end else if (p_n && c_n && !av_n && !q) begin
            m_tag = "R10";
        end else if (!p_n || !c_n) begin
            m_tag = "R3";
        end else begin
            m_tag = "R5";
        end
        @(negedge clk);
        check(m_tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; ext_addr = '0; strb_proc_n = 1; strb_ctrl_n = 1;
        start_ok = 0; adv_n = 1; beat_qual = 1; order_sel = 0;
        m_base = '0; m_beat = 0; m_busy = 0;
        repeat (3) @(negedge clk);
        check("R1");
        adv_n = 0;
        rst_n = 1;
        @(negedge clk);
        check("R1");
        // R11: advance before any load
        cyc(19'h12345, 1, 1, 0, 0, 1, 0);
        // R4: processor load with adv low
        cyc(19'h7_0001, 0, 1, 1, 0, 1, 0);
        // R6/R8 linear: 1,2,3,0 then wrap to 1
        for (int i = 0; i < 4; i++) cyc(19'h0, 1, 1, 0, 0, 1, 0);
        // R7 interleaved from start 2: 2,3,0,1
        cyc(19'h2_AAAA, 1, 0, 1, 1, 1, 1);
        for (int i = 0; i < 4; i++) cyc(19'h0, 1, 1, 0, 0, 1, 1);
        // R10 qualifier low
        cyc(19'h0, 1, 1, 0, 0, 0, 1);
        // R9 reload mid-burst
        cyc(19'h0, 1, 1, 0, 0, 1, 1);
        cyc(19'h5_5557, 1, 0, 1, 0, 1, 1);
        // R3 strobe without start
        cyc(19'h1_1111, 0, 1, 0, 0, 1, 1);
        // random
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic p_n, c_n, ok, ord;
            r = $urandom_range(0, 99);
            p_n = 1; c_n = 1; ok = 0;
            if (r < 12)      begin p_n = 0; ok = 1; end
            else if (r < 20) begin c_n = 0; ok = 1; end
            else if (r < 26) begin p_n = $urandom_range(0,1); c_n = ~p_n; ok = 0; end
            ord = ($urandom_range(0, 49) == 0) ? ~order_sel : order_sel;
            cyc(AW'($urandom), p_n, c_n, ok, logic'($urandom_range(0, 3) != 0),
                logic'($urandom_range(0, 6) != 0), ord);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule